// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Slice

A behavioural model of one programmable logic slice whose single 32-bit truth-table store is read, depending on a two-bit mode select, as two independent 4-input lookup tables, as a 5-input function, as a 16-word by 2-bit single-port RAM, or as two 16-entry read-only tables. A fifth mode-like path, ripple arithmetic, bypasses the table and adds two 2-bit operands with a carry in. The table is filled through a serial shift port while a load enable is high.

A companion read-only port addresses the same storage with the second input set and returns both bits of the addressed word. This models the read side of a dual-port RAM built from a read-write slice paired with its companion. A parameter produces a reduced slice with no RAM capability: the RAM mode select then reads the table exactly as ROM mode and no write reaches the storage.

Top module: `lut_slice`

## Requirements
- R1: An active-low reset clears all 32 table bits, so every output reads 0 in logic mode after reset.
- R2: While `cfg_en` is high, each rising clock edge moves every table bit down one place and loads `cfg_din` into bit 31; after 32 loads the k-th bit sent sits in bit k. Bits 0-15 form table A, bits 16-31 table B.
- R3: In logic mode (`mode` = 0), `f0` equals table A at index `a_in` and `f1` equals table B at index `b_in`, the index taken as an unsigned number.
- R4: In logic, RAM and ROM modes, `f5` equals `f1` when `sel5` is 1 and `f0` when `sel5` is 0, giving a 5-input function when both input sets carry the same value.
- R5: In ripple mode (`mode` = 1), `{f5, f1, f0}` equals `a_in[1:0] + b_in[1:0] + sel5`.
- R6: In RAM mode (`mode` = 2) with RAM enabled, `we` high and `cfg_en` low, the rising edge writes `wdata[0]` to table A and `wdata[1]` to table B, both at index `a_in`.
- R7: In RAM mode with RAM enabled, `f0` and `f1` read tables A and B at index `a_in` without a clock; written data appears the cycle after the write edge.
- R8: ROM mode (`mode` = 3) reads exactly as logic mode, and `we` has no effect on the table in logic, ripple and ROM modes.
- R9: `ro_q` equals `{B[b_in], A[b_in]}` in every mode, so data written through the read-write port appears on the read-only port.
- R10: With `RAM_EN` = 0, RAM mode gives the same outputs as ROM mode and writes are ignored.
- R11: When `cfg_en` and a RAM write occur in the same cycle, only the shift takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Serial table load enable |
| cfg_din | input | 1 | Serial table load data |
| mode | input | 2 | 0 logic, 1 ripple, 2 RAM, 3 ROM |
| a_in | input | LUT_K | Table A index; RAM read-write address |
| b_in | input | LUT_K | Table B index; read-only port address |
| sel5 | input | 1 | LUT5 select; carry in for ripple |
| we | input | 1 | RAM write enable |
| wdata | input | 2 | RAM write data, bit 0 to A, bit 1 to B |
| f0 | output | 1 | First table result or sum bit 0 |
| f1 | output | 1 | Second table result or sum bit 1 |
| f5 | output | 1 | LUT5 result or carry out |
| ro_q | output | 2 | Read-only port word at `b_in` |

## Verification
The assertions take for granted that `a_in` is held still across a write edge when checking readback, and that `mode` is a defined two-bit value whenever reset is released. The stimulus changes inputs only a fixed delay after each rising edge, never during a load burst except in the priority phase, and two instances (full and reduced) receive the same inputs so one stream covers both variants against a behavioural model on every clock.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
   typedef enum logic [1:0] {
      SLC_LOGIC  = 2'd0,
      SLC_RIPPLE = 2'd1,
      SLC_RAM    = 2'd2,
      SLC_ROM    = 2'd3
   } slc_mode_e;
endpackage

// File: rtl/lut_tbl_store.sv
module lut_tbl_store #(
   parameter int LUT_K = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_en,
   input  logic                   cfg_din,
   input  logic                   wr_en,
   input  logic [LUT_K-1:0]       waddr,
   input  logic [1:0]             wdata,
   output logic [2*(1<<LUT_K)-1:0] tbl
);
   localparam int DEPTH = 1 << LUT_K;
   localparam int TBL_W = 2 * DEPTH;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl <= '0;
      end else if (cfg_en) begin
         tbl <= {cfg_din, tbl[TBL_W-1:1]};
      end else if (wr_en) begin
         tbl[{1'b0, waddr}] <= wdata[0];
         tbl[{1'b1, waddr}] <= wdata[1];
      end
   end

   AST_CFG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> tbl[TBL_W-1] == $past(cfg_din)); // R2

   AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !wr_en) |=> $stable(tbl)); // R8

   AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cfg_en) |=> (tbl[{1'b0, $past(waddr)}] == $past(wdata[0]))
                          && (tbl[{1'b1, $past(waddr)}] == $past(wdata[1]))); // R6
endmodule

// File: rtl/lut_tbl_read.sv
module lut_tbl_read #(
   parameter int LUT_K = 4
) (
   input  logic [(1<<LUT_K)-1:0] tbl,
   input  logic [LUT_K-1:0]      sel,
   output logic                  q
);
   localparam int DEPTH = 1 << LUT_K;

   logic [2*DEPTH-2:0] node;

   assign node[2*DEPTH-2:DEPTH-1] = tbl;

   for (genvar n = 0; n < DEPTH - 1; n++) begin : g_mux
      localparam int LVL = $clog2(n + 2) - 1;
      assign node[n] = sel[LUT_K-1-LVL] ? node[2*n+2] : node[2*n+1];
   end

   assign q = node[0];
endmodule

// File: rtl/lut_ripple2.sv
module lut_ripple2 (
   input  logic [1:0] a,
   input  logic [1:0] b,
   input  logic       ci,
   output logic [1:0] s,
   output logic       co
);
   logic [1:0] gen, prop;
   logic       c1;

   assign gen  = a & b;
   assign prop = a ^ b;
   assign c1   = gen[0] | (prop[0] & ci);
   assign s    = {prop[1] ^ c1, prop[0] ^ ci};
   assign co   = gen[1] | (prop[1] & c1);
endmodule

// File: rtl/lut_slice.sv
module lut_slice
   import lut_slice_pkg::*;
#(
   parameter int LUT_K  = 4,
   parameter bit RAM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_din,
   input  logic [1:0]       mode,
   input  logic [LUT_K-1:0] a_in,
   input  logic [LUT_K-1:0] b_in,
   input  logic             sel5,
   input  logic             we,
   input  logic [1:0]       wdata,
   output logic             f0,
   output logic             f1,
   output logic             f5,
   output logic [1:0]       ro_q
);
   localparam int DEPTH = 1 << LUT_K;
   localparam int TBL_W = 2 * DEPTH;

   if (LUT_K < 2 || LUT_K > 6) begin : g_bad_k
      $error("lut_slice: LUT_K must lie in 2..6");
   end

   slc_mode_e        md;
   logic             ram_act;
   logic             wr_req;
   logic [TBL_W-1:0] tbl;
   logic [LUT_K-1:0] addr_b;
   logic             lut_a, lut_b;
   logic [1:0]       rip_sum;
   logic             rip_co;

   assign md = slc_mode_e'(mode);

   if (RAM_EN) begin : g_ram
      assign ram_act = (md == SLC_RAM);
   end else begin : g_no_ram
      assign ram_act = 1'b0;
   end

   assign wr_req = ram_act & we;
   assign addr_b = ram_act ? a_in : b_in;

   lut_tbl_store #(.LUT_K(LUT_K)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_en  (cfg_en),
      .cfg_din (cfg_din),
      .wr_en   (wr_req),
      .waddr   (a_in),
      .wdata   (wdata),
      .tbl     (tbl)
   );

   lut_tbl_read #(.LUT_K(LUT_K)) u_rd_a (
      .tbl (tbl[DEPTH-1:0]),
      .sel (a_in),
      .q   (lut_a)
   );

   lut_tbl_read #(.LUT_K(LUT_K)) u_rd_b (
      .tbl (tbl[TBL_W-1:DEPTH]),
      .sel (addr_b),
      .q   (lut_b)
   );

   for (genvar i = 0; i < 2; i++) begin : g_ro
      lut_tbl_read #(.LUT_K(LUT_K)) u_rd_ro (
         .tbl (tbl[i*DEPTH +: DEPTH]),
         .sel (b_in),
         .q   (ro_q[i])
      );
   end

   lut_ripple2 u_rip (
      .a  (a_in[1:0]),
      .b  (b_in[1:0]),
      .ci (sel5),
      .s  (rip_sum),
      .co (rip_co)
   );

   always_comb begin
      if (md == SLC_RIPPLE) begin
         f0 = rip_sum[0];
         f1 = rip_sum[1];
         f5 = rip_co;
      end else begin
         f0 = lut_a;
         f1 = lut_b;
         f5 = sel5 ? lut_b : lut_a;
      end
   end

   AST_RO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_act && (a_in == b_in)) |-> (ro_q == {f1, f0})); // R9

   AST_RAM_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !cfg_en) |=>
         (!(ram_act && $stable(a_in)) || ({f1, f0} == $past(wdata)))); // R7
endmodule

// File: tb/lut_slice_tb.sv
module lut_slice_tb;
   localparam int K = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_en = 1'b0;
   logic         cfg_din = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [K-1:0] a_in = '0;
   logic [K-1:0] b_in = '0;
   logic         sel5 = 1'b0;
   logic         we = 1'b0;
   logic [1:0]   wdata = 2'd0;
   logic         f0, f1, f5, nf0, nf1, nf5;
   logic [1:0]   ro_q, nro_q;

   int    checks = 0;
   int    failures = 0;
   bit    chk_on = 1'b0;
   bit    done = 1'b0;
   string tag = "R1";
   bit [31:0] m_tbl [2];

   always #4 clk = ~clk;

   lut_slice #(.LUT_K(K), .RAM_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .mode(mode),
      .a_in(a_in), .b_in(b_in), .sel5(sel5), .we(we), .wdata(wdata),
      .f0(f0), .f1(f1), .f5(f5), .ro_q(ro_q));

   lut_slice #(.LUT_K(K), .RAM_EN(1'b0)) u_dut_nr (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .mode(mode),
      .a_in(a_in), .b_in(b_in), .sel5(sel5), .we(we), .wdata(wdata),
      .f0(nf0), .f1(nf1), .f5(nf5), .ro_q(nro_q));

   function automatic bit [4:0] expect_out(bit [31:0] t, bit ram_ok);
      bit e0, e1, e5;
      int s;
      if (mode == 2'd1) begin
         s  = int'(a_in[1:0]) + int'(b_in[1:0]) + int'(sel5);
         e0 = s[0]; e1 = s[1]; e5 = s[2];
      end else begin
         e0 = t[a_in];
         e1 = (mode == 2'd2 && ram_ok) ? t[16 + a_in] : t[16 + b_in];
         e5 = sel5 ? e1 : e0;
      end
      return {t[16 + b_in], t[b_in], e5, e1, e0};
   endfunction

   always @(posedge clk) begin
      for (int v = 0; v < 2; v++) begin
         if (!rst_n) m_tbl[v] = '0;
         else if (cfg_en) m_tbl[v] = {cfg_din, m_tbl[v][31:1]};
         else if (mode == 2'd2 && v == 0 && we) begin
            m_tbl[v][a_in]      = wdata[0];
            m_tbl[v][16 + a_in] = wdata[1];
         end
      end
   end

   always @(negedge clk) begin
      if (chk_on && !done) begin
         bit [4:0] e, g;
         e = expect_out(m_tbl[0], 1'b1);
         g = {ro_q, f5, f1, f0};
         checks++;
         if (g !== e) begin
            failures++;
            $display("FAIL %s full slice: got %b expected %b (ro_q,f5,f1,f0) mode=%0d a=%0d b=%0d",
                     tag, g, e, mode, a_in, b_in);
         end
         e = expect_out(m_tbl[1], 1'b0);
         g = {nro_q, nf5, nf1, nf0};
         checks++;
         if (g !== e) begin
            failures++;
            $display("FAIL %s reduced slice R10: got %b expected %b mode=%0d a=%0d b=%0d",
                     tag, g, e, mode, a_in, b_in);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic load(bit [31:0] v);
      cfg_en = 1'b1;
      for (int k = 0; k < 32; k++) begin
         cfg_din = v[k];
         step();
      end
      cfg_en = 1'b0;
      step();
   endtask

   initial begin
      bit [31:0] pat;
      repeat (3) step();
      rst_n = 1'b1;
      chk_on = 1'b1;
      tag = "R1";
      for (int i = 0; i < 16; i++) begin a_in = i[3:0]; b_in = i[3:0]; step(); end

      // R2 R3: load tables then sweep all 16 combinations of each table
      foreach (pat[j]) pat[j] = 1'b0;
      for (int r = 0; r < 4; r++) begin
         tag = "R2 R3";
         pat = (r == 0) ? 32'hA5C3_0FF1 : $urandom();
         mode = 2'd0;
         load(pat);
         for (int i = 0; i < 16; i++) begin
            a_in = i[3:0]; b_in = 4'(15 - i); sel5 = 1'b0; step();
         end
         tag = "R4";
         for (int i = 0; i < 32; i++) begin
            a_in = i[3:0]; b_in = i[3:0]; sel5 = i[4]; step();
         end
         tag = "R8";
         mode = 2'd3;
         for (int i = 0; i < 16; i++) begin
            a_in = i[3:0]; b_in = $urandom(); sel5 = $urandom(); we = 1'b1;
            wdata = $urandom(); step();
         end
         mode = 2'd0;
         for (int i = 0; i < 8; i++) begin
            a_in = $urandom(); b_in = $urandom(); wdata = $urandom(); step();
         end
         we = 1'b0;
      end

      tag = "R5";
      mode = 2'd1;
      for (int i = 0; i < 32; i++) begin
         a_in = {2'($urandom()), i[1:0]}; b_in = {2'($urandom()), i[3:2]};
         sel5 = i[4]; we = i[0]; wdata = $urandom(); step();
      end
      we = 1'b0;

      tag = "R6 R7 R9 R10";
      mode = 2'd2;
      for (int i = 0; i < 16; i++) begin
         a_in = i[3:0]; b_in = i[3:0]; we = 1'b1; wdata = $urandom(); step();
         we = 1'b0; step();
      end
      for (int i = 0; i < 16; i++) begin
         a_in = $urandom(); b_in = i[3:0]; sel5 = $urandom(); step();
      end
      for (int i = 0; i < 24; i++) begin
         a_in = $urandom(); b_in = $urandom(); we = $urandom(); wdata = $urandom(); step();
      end
      we = 1'b0;

      tag = "R11";
      cfg_en = 1'b1;
      for (int i = 0; i < 10; i++) begin
         cfg_din = $urandom(); a_in = $urandom(); b_in = $urandom();
         we = 1'b1; wdata = $urandom(); step();
      end
      cfg_en = 1'b0; we = 1'b0;
      for (int i = 0; i < 16; i++) begin a_in = i[3:0]; b_in = i[3:0]; step(); end

      tag = "R8";
      mode = 2'd3;
      for (int i = 0; i < 16; i++) begin a_in = i[3:0]; b_in = 4'(15 - i); step(); end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule